// File: doc/BRIEF.md
# Saturating Unsigned Narrowing Shifter

This block is one datapath slice of a vector unit. It takes a 128-bit register holding signed wide elements. Each element is shifted right by an immediate amount. The result is clamped into the unsigned range of an element half as wide, and the narrow values are packed back into the wide lane positions. All lanes of the vector are handled in the same cycle. The lanes are eight 16-bit, four 32-bit or two 64-bit elements, as the element-size code selects.

A 4-bit operation code chooses between truncating and rounding shifts. It also chooses whether the narrow value goes to the bottom half or the top half of each lane. For top placement the lower half of each lane is taken from the old destination vector, so two operations can fill one register. The inputs are captured on each rising clock edge. The result and an error flag appear one cycle later. An operation that is not legal raises the error flag and returns the old destination unchanged.

Top module: `sat_narrow_shifter`

## Requirements
- R1: `result` and `err` are registered and reflect the inputs present at the previous rising edge; while `rst_n` is low both are zero.
- R2: Size code 1, 2 or 3 selects wide lanes of 16, 32 or 64 bits. The narrow width is 4 shifted left by the code (8, 16 or 32 bits). Every lane of the 128-bit vector is processed in parallel, with lane i occupying bits [i*W +: W].
- R3: Each wide lane is read as a two's-complement value and shifted right arithmetically by `shamt`, with the sign extended.
- R4: A shifted value that is negative yields a narrow result of 0.
- R5: A shifted value greater than 2^N-1, where N is the narrow width, yields the all-ones narrow value 2^N-1.
- R6: For the rounding variant, 2^(shamt-1) is added to the sign-extended lane with one bit of headroom before the shift. The most positive element therefore never wraps to a negative value.
- R7: For bottom placement the narrow value fills bits [N-1:0] of the lane and bits [W-1:N] are zero.
- R8: For top placement the narrow value fills bits [W-1:N] of the lane and bits [N-1:0] equal the old destination's bits.
- R9: Op encoding: bit 0 = 1 selects top placement, and bit 1 = 1 selects rounding. Codes 0000, 0001, 0010 and 0011 are legal; any code with bit 2 or bit 3 set is illegal.
- R10: Size code 0, `shamt` of 0, `shamt` greater than N, or an illegal op sets `err` to 1 and makes `result` equal to the old destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 128 | Source vector of signed wide elements |
| old_dst | input | 128 | Previous destination contents |
| size_code | input | 2 | Wide element size code (1/2/3 = 16/32/64 bits) |
| op | input | 4 | Operation code: bit 0 top placement, bit 1 rounding |
| shamt | input | 6 | Right-shift immediate |
| result | output | 128 | Packed narrowed result vector |
| err | output | 1 | Illegal operation flag |

## Verification
The bench sweeps every size, every legal shift and every op. Each lane gets a value from a boundary set: the most negative value, -1, 0, the first value that saturates and its two neighbours, and the most positive value. A design that extended the sign badly, or clamped on the unshifted value, would be off by one lane exactly at the saturation threshold. It would also turn large negative inputs into the all-ones maximum. Rounding on the most positive element is aimed at missing headroom: a design without it wraps the sum and returns 0 where the correct result is a mid-range value. Top placement runs with a patterned old destination, and the illegal cases (size 0, shift 0 or past the narrow width, reserved op bits) run with the same pattern. This exposes a design that clears the preserved halves or writes the vector on an error.

// File: rtl/sqn_pkg.sv
package sqn_pkg;
    localparam int VEC_BITS   = 128;
    localparam int SHAMT_BITS = 6;

    typedef struct packed {
        logic legal;
        logic round;
        logic top;
    } mode_t;
endpackage

// File: rtl/sqn_decode.sv
module sqn_decode
    import sqn_pkg::*;
#(
    parameter int SHIFT_W = SHAMT_BITS
) (
    input  logic [1:0]         size_code,
    input  logic [3:0]         op,
    input  logic [SHIFT_W-1:0] shamt,
    output mode_t              mode
);
    logic [SHIFT_W:0] narrow_bits;
    logic             shamt_ok;

    always_comb begin
        narrow_bits = (SHIFT_W+1)'(4) << size_code;
        shamt_ok    = (shamt != '0) && ({1'b0, shamt} <= narrow_bits);
        mode.legal  = (size_code != 2'd0) && (op[3:2] == 2'b00) && shamt_ok;
        mode.round  = op[1];
        mode.top    = op[0];
    end
endmodule

// File: rtl/sqn_lane.sv
module sqn_lane #(
    parameter int WIDE_W  = 16,
    parameter int SHIFT_W = 6
) (
    input  logic [WIDE_W-1:0]  src_lane,
    input  logic [WIDE_W-1:0]  old_lane,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               round_en,
    input  logic               top_en,
    output logic [WIDE_W-1:0]  lane_out
);
    localparam int NARROW_W = WIDE_W / 2;
    localparam int EXT_W    = WIDE_W + 1;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shifted;
    logic [NARROW_W-1:0]     narrow;

    always_comb begin
        ext  = {src_lane[WIDE_W-1], src_lane};
        bias = '0;
        if (round_en && (shamt != '0)) begin
            bias = $signed(EXT_W'(1) << (shamt - SHIFT_W'(1)));
        end
        sum     = ext + bias;
        shifted = sum >>> shamt;
        if (shifted[EXT_W-1]) begin
            narrow = '0;
        end else if (|shifted[EXT_W-2:NARROW_W]) begin
            narrow = '1;
        end else begin
            narrow = shifted[NARROW_W-1:0];
        end
        if (top_en) begin
            lane_out = {narrow, old_lane[NARROW_W-1:0]};
        end else begin
            lane_out = {{NARROW_W{1'b0}}, narrow};
        end
    end
endmodule

// File: rtl/sqn_bank.sv
module sqn_bank #(
    parameter int VEC_W   = 128,
    parameter int WIDE_W  = 16,
    parameter int SHIFT_W = 6
) (
    input  logic [VEC_W-1:0]   src,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               round_en,
    input  logic               top_en,
    output logic [VEC_W-1:0]   bank_out
);
    localparam int LANES = VEC_W / WIDE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sqn_lane #(
            .WIDE_W (WIDE_W),
            .SHIFT_W(SHIFT_W)
        ) u_lane (
            .src_lane(src[i*WIDE_W +: WIDE_W]),
            .old_lane(old_dst[i*WIDE_W +: WIDE_W]),
            .shamt   (shamt),
            .round_en(round_en),
            .top_en  (top_en),
            .lane_out(bank_out[i*WIDE_W +: WIDE_W])
        );
    end
endmodule

// File: rtl/sat_narrow_shifter.sv
module sat_narrow_shifter
    import sqn_pkg::*;
#(
    parameter int VEC_W   = VEC_BITS,
    parameter int SHIFT_W = SHAMT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VEC_W-1:0]   src,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic [1:0]         size_code,
    input  logic [3:0]         op,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [VEC_W-1:0]   result,
    output logic               err
);
    localparam int MIN_SIZE = 1;
    localparam int MAX_SIZE = 3;

    typedef struct packed {
        logic [VEC_W-1:0] result;
        logic             err;
    } state_t;

    mode_t            mode;
    logic [VEC_W-1:0] bank_out [MIN_SIZE:MAX_SIZE];
    state_t           state_d;
    state_t           state_q;

    sqn_decode #(.SHIFT_W(SHIFT_W)) u_decode (
        .size_code(size_code),
        .op       (op),
        .shamt    (shamt),
        .mode     (mode)
    );

    for (genvar k = MIN_SIZE; k <= MAX_SIZE; k++) begin : g_size
        sqn_bank #(
            .VEC_W  (VEC_W),
            .WIDE_W (8 << k),
            .SHIFT_W(SHIFT_W)
        ) u_bank (
            .src     (src),
            .old_dst (old_dst),
            .shamt   (shamt),
            .round_en(mode.round),
            .top_en  (mode.top),
            .bank_out(bank_out[k])
        );
    end

    always_comb begin
        state_d.err    = !mode.legal;
        state_d.result = old_dst;
        if (mode.legal) begin
            case (size_code)
                2'd1:    state_d.result = bank_out[1];
                2'd2:    state_d.result = bank_out[2];
                2'd3:    state_d.result = bank_out[3];
                default: state_d.result = old_dst;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.result;
    assign err    = state_q.err;
endmodule

// File: rtl/sqn_checker.sv
module sqn_checker #(
    parameter int VEC_W   = 128,
    parameter int SHIFT_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VEC_W-1:0]   src,
    input logic [VEC_W-1:0]   old_dst,
    input logic [1:0]         size_code,
    input logic [3:0]         op,
    input logic [SHIFT_W-1:0] shamt,
    input logic [VEC_W-1:0]   result,
    input logic               err
);
    logic ok_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= 1'b1;
    end

    function automatic logic [VEC_W-1:0] hi_mask(input logic [1:0] s);
        int wide;
        int half;
        hi_mask = '0;
        wide = 8 << s;
        half = 4 << s;
        for (int i = 0; i < VEC_W; i++) begin
            if ((i % wide) >= half) hi_mask[i] = 1'b1;
        end
    endfunction

    AST_ILLEGAL_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && err) |-> (result == $past(old_dst))); // R10

    AST_SIZE0_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && ($past(size_code) == 2'd0)) |-> err); // R10

    AST_RESERVED_OP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && ($past(op[3:2]) != 2'b00)) |-> err); // R9

    AST_BOTTOM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && !err && !$past(op[0])) |->
        ((result & hi_mask($past(size_code))) == '0)); // R7

    AST_TOP_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q && !err && $past(op[0])) |->
        ((result & ~hi_mask($past(size_code))) ==
         ($past(old_dst) & ~hi_mask($past(size_code))))); // R8
endmodule

bind sat_narrow_shifter sqn_checker #(
    .VEC_W  (VEC_W),
    .SHIFT_W(SHIFT_W)
) u_sqn_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .old_dst  (old_dst),
    .size_code(size_code),
    .op       (op),
    .shamt    (shamt),
    .result   (result),
    .err      (err)
);

// File: tb/test_sat_narrow_shifter.sv
module test_sat_narrow_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] src = '0;
    logic [VW-1:0] old_dst = '0;
    logic [1:0]    size_code = 2'd0;
    logic [3:0]    op = 4'd0;
    logic [5:0]    shamt = 6'd0;
    logic [VW-1:0] result;
    logic          err;

    int checks = 0;
    int failures = 0;
    logic [VW:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_narrow_shifter i_sat_narrow_shifter (
        .clk(clk), .rst_n(rst_n), .src(src), .old_dst(old_dst),
        .size_code(size_code), .op(op), .shamt(shamt),
        .result(result), .err(err)
    );

    // Reference: {err, result} from the requirements.
    function automatic logic [VW:0] model(input logic [VW-1:0] s, input logic [VW-1:0] od,
                                          input logic [1:0] sz, input logic [3:0] o,
                                          input logic [5:0] sh);
        int w, n, lanes;
        logic [VW-1:0] res;
        logic [63:0] raw, nv, wmask, nmask;
        logic signed [65:0] v, mx;
        n = 4 << sz;
        w = 8 << sz;
        if (sz == 2'd0 || o[3:2] != 2'b00 || sh == 0 || int'(sh) > n)
            return {1'b1, od};
        lanes = VW / w;
        wmask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        nmask = (64'd1 << n) - 64'd1;
        res = '0;
        for (int i = 0; i < lanes; i++) begin
            raw = 64'(s >> (i*w)) & wmask;
            if (raw[w-1]) v = $signed({2'b11, raw | ~wmask});
            else          v = $signed({2'b00, raw});
            if (o[1]) v = v + ($signed(66'd1) <<< (sh - 1));
            v = v >>> sh;
            mx = $signed((66'd1 << n) - 66'd1);
            if (v < 0)       nv = 64'd0;
            else if (v > mx) nv = nmask;
            else             nv = 64'(v);
            if (o[0]) nv = (nv << n) | (64'(od >> (i*w)) & nmask);
            res = res | (VW'(nv) << (i*w));
        end
        return {1'b0, res};
    endfunction

    task automatic send(input logic [VW-1:0] s, input logic [VW-1:0] od, input logic [1:0] sz,
                        input logic [3:0] o, input logic [5:0] sh, input string tag);
        @(negedge clk);
        src = s; old_dst = od; size_code = sz; op = o; shamt = sh;
        exp_q.push_back(model(s, od, sz, o, sh));
        tag_q.push_back(tag);
    endtask

    // Monitor: the result of inputs captured at an edge is read just after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [VW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({err, result} !== e) begin
                    failures++;
                    $display("FAIL %s: got err=%b result=%h expected err=%b result=%h",
                             t, err, result, e[VW], e[VW-1:0]);
                end
            end
        end
    end

    task automatic check_now(input logic [VW:0] e, input string tag);
        checks++;
        if ({err, result} !== e) begin
            failures++;
            $display("FAIL %s: got err=%b result=%h expected err=%b result=%h",
                     tag, err, result, e[VW], e[VW-1:0]);
        end
    endtask

    function automatic logic [63:0] bval(input int idx, input int w, input int n, input int sh);
        logic [63:0] thr, mostpos, mostneg;
        mostpos = (w == 64) ? 64'h7FFF_FFFF_FFFF_FFFF : ((64'd1 << (w-1)) - 64'd1);
        mostneg = 64'd1 << (w-1);
        thr = ((64'd1 << n) << sh);
        case (idx % 8)
            0: return mostneg;
            1: return '1;
            2: return 64'd0;
            3: return thr - 64'd1;
            4: return thr;
            5: return thr + 64'd1;
            6: return mostpos;
            default: return 64'd5 << (sh - 1);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        logic [VW-1:0] pat;
        pat = {4{32'hA5C3_961E}};
        repeat (3) @(posedge clk);
        #1;
        check_now('0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: before the capturing edge the output still holds the reset value
        src = {8{16'h0123}}; old_dst = pat; size_code = 2'd1; op = 4'b0000; shamt = 6'd4;
        #1;
        check_now('0, "R1 latency");
        exp_q.push_back({1'b0, {8{16'h0012}}});
        tag_q.push_back("R1 registered");

        send({8{16'h0123}}, pat, 2'd1, 4'b0000, 6'd4, "R3 truncating shift");
        send({2{32'h8000_0000, 32'hFFFF_FFFF}}, pat, 2'd2, 4'b0000, 6'd3, "R4 negative clamps to zero");
        send({2{64'h7FFF_FFFF_FFFF_FFFF}}, pat, 2'd3, 4'b0000, 6'd1, "R5 clamp to max");
        send({8{16'h7FFF}}, pat, 2'd1, 4'b0010, 6'd8, "R6 rounding headroom");
        send({8{16'h0180}}, pat, 2'd1, 4'b0010, 6'd8, "R6 rounding up");
        send({2{64'h7FFF_FFFF_FFFF_FFFF}}, pat, 2'd3, 4'b0010, 6'd32, "R6 rounding 64-bit max");
        send({4{32'h0001_2345}}, '1, 2'd2, 4'b0000, 6'd2, "R7 bottom clears upper halves");
        send({4{32'h0001_2345}}, pat, 2'd2, 4'b0001, 6'd2, "R8 top keeps lower halves");
        send({4{32'h0001_2345}}, pat, 2'd2, 4'b0011, 6'd2, "R9 op 0011 rounding top");
        send({4{32'h0001_2345}}, pat, 2'd2, 4'b0100, 6'd2, "R9 reserved op bit");
        send({4{32'h0001_2345}}, pat, 2'd2, 4'b1000, 6'd2, "R9 reserved op bit");
        send({8{16'h0123}}, pat, 2'd0, 4'b0000, 6'd2, "R10 size zero");
        send({8{16'h0123}}, pat, 2'd1, 4'b0000, 6'd0, "R10 shift zero");
        send({8{16'h0123}}, pat, 2'd1, 4'b0001, 6'd9, "R10 shift past narrow width");
        send({8{16'h0123}}, pat, 2'd1, 4'b0000, 6'd8, "R10 shift equal narrow width legal");

        for (int seed = 0; seed < 4; seed++) begin
            for (int sz = 1; sz <= 3; sz++) begin
                for (int sh = 1; sh <= (4 << sz); sh++) begin
                    for (int o = 0; o < 4; o++) begin
                        logic [VW-1:0] s;
                        int w;
                        w = 8 << sz;
                        s = '0;
                        for (int i = 0; i < VW / w; i++)
                            s = s | (VW'(bval(i + seed + sh + o, w, 4 << sz, sh)
                                      & ((w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1)))
                                     << (i*w));
                        send(s, pat ^ VW'(seed), 2'(sz), 4'(o), 6'(sh), "R2 lane sweep");
                    end
                end
            end
        end
        repeat (3) @(posedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule